// File: doc/BRIEF.md
# Configuration Register Target for a Two-Wire Serial Bus

This block is an I2C target that holds a bank of 8-bit configuration registers. A bus controller reaches them through an 8-bit sub-address pointer. The target filters SCL and SDA into the system clock domain and watches for START and STOP conditions. It compares each address byte against its own 7-bit bus address, and it pulls SDA low through an open-drain enable whenever it acknowledges or sends a zero bit.

To write, the controller sends the address byte with the write direction, then the sub-address, then any number of data bytes. To read, the controller first loads the sub-address with a short write. It then issues a repeated START and the address byte with the read direction, and clocks data out until it answers a byte with NACK. Each data byte that is written or read advances the pointer by one, and the pointer wraps from the top of the bank to zero. One strap input sets the lowest bit of the bus address, so two of these targets can share one bus.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and each register at index i holds the default value (i XOR 5Ah), for example 10h holds 4Ah.
- R2: The 7-bit bus address is 21h when `addr_strap` is 0 (write byte 42h, read byte 43h) and 20h when `addr_strap` is 1 (write byte 40h, read byte 41h). A matching address byte is acknowledged by driving SDA low during the ninth SCL pulse.
- R3: When an address byte does not match, the target never drives SDA until the next START, and the data bytes that follow change no register.
- R4: In a write transfer the target acknowledges the sub-address byte and every data byte, and stores each data byte, MSB first on the wire, at the current pointer.
- R5: After each data byte that is written, the pointer advances by one, so consecutive bytes land in consecutive registers.
- R6: After a repeated START with the read direction, the target returns bytes MSB first starting at the loaded sub-address, advancing one register per byte. It continues while the controller answers ACK, releases SDA on NACK, and drives nothing more until the next START.
- R7: The pointer wraps from FFh to 00h, both when writing and when reading.
- R8: The target changes `sda_oe` only while SCL is low.
- R9: A STOP condition returns the target to idle with SDA released, and a new transfer after it is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| addr_strap | input | 1 | Selects the lowest bit of the bus address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
A wrong bit counter or a wrong state shows within a single byte. The acknowledge lands on the wrong SCL pulse, or it is missing, and the controller sees it at that byte's ninth pulse. A pointer that fails to step or to wrap does not show during the write that caused it. It shows only on a later read transfer, so each block write is followed by a read of the same range, including across FFh. A decoder that answers a foreign address drives SDA low within about four clock cycles after SCL falls, and the bench watches `sda_oe` during foreign transfers to catch this.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUBA,
    ST_SUBA_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_pipe, sda_pipe;
  logic       scl_prev, sda_prev;

  // two-flop synchronizers plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= 2'b11;
      sda_pipe <= 2'b11;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[0], scl_i};
      sda_pipe <= {sda_pipe[0], sda_i};
      scl_prev <= scl_pipe[1];
      sda_prev <= sda_pipe[1];
    end
  end

  assign scl_s     = scl_pipe[1];
  assign sda_s     = sda_pipe[1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile #(
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter logic [DW-1:0] DEF_XOR = 8'h5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i) ^ DEF_XOR;
      rdata <= '0;
    end else begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter int         SUB_W    = 8,
  parameter logic [6:0] DEV_BASE = 7'h21,
  parameter logic [7:0] DEF_XOR  = 8'h5A
) (
  input  logic clk,
  input  logic rst,
  input  logic addr_strap,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2c_cfg_pkg::*;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  tgt_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, tx_byte, wr_data, rd_data;
  logic [SUB_W-1:0]  ptr;
  logic              dir_rd, ctl_ack, wr_en;
  logic [6:0]        own_addr;

  assign own_addr = {DEV_BASE[6:1], DEV_BASE[0] ^ addr_strap};
  wire byte_done  = (bit_cnt == CNT_W'(BYTE_W));

  i2c_cfg_regfile #(.AW(SUB_W), .DW(BYTE_W), .DEF_XOR(DEF_XOR)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en),
    .addr (ptr),
    .wdata(wr_data),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      tx_byte <= '0;
      wr_data <= '0;
      ptr     <= '0;
      dir_rd  <= 1'b0;
      ctl_ack <= 1'b0;
      wr_en   <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise) begin
          if (state inside {ST_ADDR, ST_SUBA, ST_WDATA}) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (state == ST_RDATA) bit_cnt <= bit_cnt + 1'b1;
          if (state == ST_RACK)  ctl_ack <= ~sda_s;
        end
        if (scl_fall) begin
          case (state)
            ST_ADDR: if (byte_done) begin
              bit_cnt <= '0;
              if (shreg[7:1] == own_addr) begin
                dir_rd <= shreg[0];
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_ADDR_ACK: begin
              bit_cnt <= '0;
              if (dir_rd) begin
                tx_byte <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                state   <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_SUBA;
              end
            end
            ST_SUBA: if (byte_done) begin
              ptr     <= shreg[SUB_W-1:0];
              bit_cnt <= '0;
              sda_oe  <= 1'b1;
              state   <= ST_SUBA_ACK;
            end
            ST_SUBA_ACK: begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
            ST_WDATA: if (byte_done) begin
              wr_en   <= 1'b1;
              wr_data <= shreg;
              bit_cnt <= '0;
              sda_oe  <= 1'b1;
              state   <= ST_WDATA_ACK;
            end
            ST_WDATA_ACK: begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              state  <= ST_WDATA;
            end
            ST_RDATA: begin
              if (byte_done) begin
                sda_oe  <= 1'b0;
                ptr     <= ptr + 1'b1;
                bit_cnt <= '0;
                state   <= ST_RACK;
              end else begin
                sda_oe <= ~tx_byte[3'd7 - bit_cnt[2:0]];
              end
            end
            ST_RACK: begin
              if (ctl_ack) begin
                tx_byte <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                bit_cnt <= '0;
                state   <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R8: the drive only moves after SCL has gone low
  a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (scl_s && !start_det && !stop_det) |=> $stable(sda_oe));

  // R9: STOP leaves the target idle and silent
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_oe));

  // R3: an idle or unaddressed target never pulls SDA
  a_r3_idle_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R4: every acknowledge slot of the target drives SDA low
  a_r4_ack_slot_driven: assert property (@(posedge clk) disable iff (rst)
    (state inside {ST_ADDR_ACK, ST_SUBA_ACK, ST_WDATA_ACK}) |-> sda_oe);

  // R6: the controller's acknowledge slot is left free
  a_r6_ctl_ack_free: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACK) |-> !sda_oe);
endmodule

// File: tb/i2c_cfg_target_bench.sv
module i2c_cfg_target_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_low = 1'b0;
  logic sda_oe;
  logic sda_line;

  assign sda_line = ~(sda_low | sda_oe);
  always #2 clk = ~clk;

  i2c_cfg_target u_i2c_cfg_target (
    .clk       (clk),
    .rst       (rst),
    .addr_strap(strap),
    .scl_i     (scl_drv),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe)
  );

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t       expq[$];
  logic [7:0] gotq[$];
  logic [7:0] model [256];
  logic [7:0] data_q[$];
  int checks = 0;
  int errors = 0;
  int hold_viol = 0;
  bit oe_seen = 0;
  logic oe_prev = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares returned read bytes against expectations
  initial forever begin
    @(negedge clk);
    while (gotq.size() > 0 && expq.size() > 0) begin
      exp_t e;
      logic [7:0] g;
      e = expq.pop_front();
      g = gotq.pop_front();
      check(g == e.val, e.req, "read byte", g, e.val);
    end
  end

  // R8 watcher: drive changes while SCL high; R3 watcher: any drive seen
  always @(negedge clk) begin
    if (!rst) begin
      if (scl_drv && sda_oe !== oe_prev) hold_viol++;
      if (sda_oe) oe_seen = 1;
      oe_prev = sda_oe;
    end
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_low = 0; wq(); scl_drv = 1; wq(); sda_low = 1; wq(); scl_drv = 0; wq();
  endtask

  task automatic bus_stop();
    sda_low = 1; wq(); scl_drv = 1; wq(); sda_low = 0; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    sda_low = !b; wq(); scl_drv = 1; wq(); wq(); scl_drv = 0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_low = 0; wq(); scl_drv = 1; wq(); b = sda_line; wq(); scl_drv = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(last);
  endtask

  // write data_q starting at sub; a matching device updates the model
  task automatic wr_regs(input logic [7:0] dev, input logic [7:0] sub, input bit exp_ack,
                         input string req);
    bit ack;
    bus_start();
    send_byte(dev, ack);
    check(ack == exp_ack, req, "address ack", ack, exp_ack);
    if (ack) begin
      send_byte(sub, ack);
      check(ack, req, "sub-address ack", ack, 1);
      foreach (data_q[k]) begin
        send_byte(data_q[k], ack);
        check(ack, req, "data ack", ack, 1);
        model[8'(sub + k)] = data_q[k];
      end
    end else begin
      send_byte(sub, ack);
      foreach (data_q[k]) send_byte(data_q[k], ack);
    end
    bus_stop();
  endtask

  task automatic rd_regs(input logic [7:0] dev, input logic [7:0] sub, input int n,
                         input string req);
    bit ack;
    logic [7:0] v;
    bus_start();
    send_byte(dev, ack);
    check(ack, req, "address ack", ack, 1);
    send_byte(sub, ack);
    check(ack, req, "sub-address ack", ack, 1);
    bus_start();
    send_byte(dev | 8'h01, ack);
    check(ack, req, "read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      expq.push_back('{model[8'(sub + k)], req});
      recv_byte(k == n - 1, v);
      gotq.push_back(v);
    end
    @(negedge clk);
    @(negedge clk);
    check(sda_oe == 1'b0, "R6", "drive after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'h5A;
    repeat (5) @(posedge clk);
    #1 rst = 0;
    wq();
    check(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);

    // R1: defaults visible through a read, e.g. 10h holds 4Ah
    rd_regs(8'h42, 8'h10, 3, "R1");

    // R4 R5: burst write then read back
    data_q = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
    wr_regs(8'h42, 8'h30, 1, "R4");
    rd_regs(8'h42, 8'h30, 4, "R5");

    // R7: write and read across the FFh to 00h wrap
    data_q = '{8'h81, 8'h7E, 8'h55, 8'hC3};
    wr_regs(8'h42, 8'hFE, 1, "R7");
    rd_regs(8'h42, 8'hFE, 4, "R7");

    // R3: foreign address is not acknowledged, never driven, stores nothing
    oe_seen = 0;
    data_q = '{8'h99, 8'h98};
    wr_regs(8'h50, 8'h30, 0, "R3");
    check(oe_seen == 0, "R3", "SDA driven for foreign address", oe_seen, 0);
    rd_regs(8'h42, 8'h30, 2, "R3");

    // R2: strap moves the address to 20h (40h/41h); 42h is then foreign
    strap = 1;
    wq();
    oe_seen = 0;
    data_q = '{8'h11};
    wr_regs(8'h42, 8'h31, 0, "R2");
    check(oe_seen == 0, "R2", "SDA driven for old address", oe_seen, 0);
    data_q = '{8'h6D, 8'h6E};
    wr_regs(8'h40, 8'h50, 1, "R2");
    rd_regs(8'h40, 8'h4F, 4, "R6");

    // R9: after STOP the bus is released and a new transfer works
    check(sda_oe == 1'b0, "R9", "sda_oe after STOP", sda_oe, 0);
    strap = 0;
    wq();
    data_q = '{8'h24};
    wr_regs(8'h42, 8'h00, 1, "R9");
    rd_regs(8'h42, 8'h00, 1, "R9");

    wait (expq.size() == 0);
    @(negedge clk);
    check(hold_viol == 0, "R8", "drive changes while SCL high", hold_viol, 0);
    finish_run();
  end
endmodule